// File: doc/BRIEF.md
# Receive FIFO Burst Writer

This block drains read data from an internal data buffer into a user-side receive FIFO. It always moves data in fixed bursts of 32 words of 128 bits, which is 512 bytes or one sector. A command arrives as a one-cycle start strobe that carries a length in sectors. The block then issues one burst per sector until the whole length has been written. After that it drops busy and pulses done for one cycle.

Before each burst the block checks two things: there must be room in the user FIFO, and the internal buffer must already hold a full burst. Room is read from the upper bits of the FIFO's 16-bit write count. A FIFO whose own count is narrower than 16 bits pads the missing upper bits with ones, so it looks full when it is close to full. The internal buffer has a registered read port with one cycle of latency. The block reads it one cycle ahead, so each word reaches the FIFO in the same cycle as its write enable. A zero length is refused, and so is any start that arrives while a command is already running.

Top module: `rx_burst_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, fifo_wr_en and buf_rd_en are all 0.
- R2: A start with a nonzero length taken while idle raises busy in the next cycle. When both gates are open, buf_rd_en first rises 2 cycles after the start is sampled and fifo_wr_en first rises 3 cycles after it.
- R3: Every burst is exactly 32 consecutive cycles of fifo_wr_en high.
- R4: The buffer port returns a word one cycle after buf_rd_en. fifo_wr_data carries the buffer words in the order they were read, one word per fifo_wr_en cycle, and buf_rd_en leads fifo_wr_en by one cycle.
- R5: A burst starts only while fifo_wr_cnt[15:6] is not all ones (not 1023). fifo_wr_cnt[5:0] have no effect.
- R6: A burst starts only while buf_level, the number of 128-bit words in the buffer, is at least 32.
- R7: While both gates stay open, fifo_wr_en is low for exactly one cycle between consecutive bursts of a command.
- R8: A command of N sectors writes exactly 32*N words in N bursts. Busy falls in the cycle after the last write, and done pulses high for that one cycle only.
- R9: A start with length 0 is ignored: busy stays 0, and no read, write or done occurs.
- R10: A start that arrives while busy is ignored. The running command ends with its own length, and no second command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle command strobe |
| start_len | input | LEN_W (32) | Transfer length in 512-byte sectors, sampled with start |
| busy | output | 1 | High from the cycle after an accepted start until the command ends |
| done | output | 1 | One-cycle pulse when a command ends |
| fifo_wr_cnt | input | CNT_W (16) | Write count of the user FIFO, upper bits padded with ones |
| fifo_wr_en | output | 1 | Write enable to the user FIFO |
| fifo_wr_data | output | DATA_W (128) | Write data to the user FIFO |
| buf_level | input | LVL_W (10) | Words held in the internal buffer |
| buf_rd_en | output | 1 | Read request to the internal buffer |
| buf_rd_data | input | DATA_W (128) | Buffer read data, valid one cycle after buf_rd_en |

## Verification
Busy is due one cycle after the start is sampled. The first buffer read is due two cycles after it and the first FIFO write three cycles after it. Busy falls and done pulses one cycle after the last write. The bench drives inputs on the falling edge and reads outputs on later falling edges, counting cycles from the one that drove the start, so every check lands on the exact cycle these latencies give. For the gating checks, the bench holds a gate closed for a fixed number of cycles and confirms that no write appears. It then opens the gate and counts the words of the burst that follows. The gaps between bursts are measured in cycles of write enable low.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } rbw_state_e;

endpackage

// File: rtl/rbw_launch_gate.sv
module rbw_launch_gate #(
    parameter int CNT_W       = 16,
    parameter int SPACE_LSB   = 6,
    parameter int LVL_W       = 10,
    parameter int BURST_WORDS = 32
) (
    input  logic [CNT_W-1:0] fifo_wr_cnt,
    input  logic [LVL_W-1:0] buf_level,
    output logic             launch_ok
);
    // Low count bits are forced to one so only the upper field decides room.
    localparam logic [CNT_W-1:0] LOW_ONES  = CNT_W'((1 << SPACE_LSB) - 1);
    localparam logic [LVL_W-1:0] MIN_LEVEL = LVL_W'(BURST_WORDS);

    logic [CNT_W-1:0] cnt_masked;
    logic             space_ok;
    logic             data_ok;

    always_comb begin
        cnt_masked = fifo_wr_cnt | LOW_ONES;
        space_ok   = ~&cnt_masked;
        data_ok    = (buf_level >= MIN_LEVEL);
        launch_ok  = space_ok && data_ok;
    end

endmodule

// File: rtl/rbw_beat_ctr.sv
module rbw_beat_ctr #(
    parameter int BURST_WORDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int BEAT_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_WORDS - 1);

    logic [BEAT_W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        last   = run && (beat_q == LAST_BEAT);
        if (run) begin
            beat_d = last ? '0 : beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

endmodule

// File: rtl/rx_burst_writer.sv
module rx_burst_writer #(
    parameter int DATA_W      = 128,
    parameter int BURST_WORDS = 32,
    parameter int CNT_W       = 16,
    parameter int SPACE_LSB   = 6,
    parameter int LEN_W       = 32,
    parameter int LVL_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    output logic              done,
    input  logic [CNT_W-1:0]  fifo_wr_cnt,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    input  logic [LVL_W-1:0]  buf_level,
    output logic              buf_rd_en,
    input  logic [DATA_W-1:0] buf_rd_data
);
    import rbw_pkg::*;

    typedef struct packed {
        rbw_state_e       state;
        logic [LEN_W-1:0] left;
        logic             wr_en;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;
    logic  launch_ok;
    logic  beat_last;
    logic  reading;

    assign reading = (r_q.state == ST_READ);

    rbw_launch_gate #(
        .CNT_W      (CNT_W),
        .SPACE_LSB  (SPACE_LSB),
        .LVL_W      (LVL_W),
        .BURST_WORDS(BURST_WORDS)
    ) u_gate (
        .fifo_wr_cnt(fifo_wr_cnt),
        .buf_level  (buf_level),
        .launch_ok  (launch_ok)
    );

    rbw_beat_ctr #(
        .BURST_WORDS(BURST_WORDS)
    ) u_beats (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (reading),
        .last (beat_last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        // Write enable trails the buffer read by the port's one-cycle latency.
        r_d.wr_en = reading;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start && (start_len != '0)) begin
                    r_d.state = ST_WAIT;
                    r_d.left  = start_len;
                end
            end
            ST_WAIT: begin
                if (launch_ok) begin
                    r_d.state = ST_READ;
                    r_d.left  = r_q.left - 1'b1;
                end
            end
            ST_READ: begin
                if (beat_last) begin
                    r_d.state = (r_q.left == '0) ? ST_DRAIN : ST_WAIT;
                end
            end
            ST_DRAIN: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, left: '0, wr_en: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.state != ST_IDLE);
    assign done         = r_q.done;
    assign buf_rd_en    = reading;
    assign fifo_wr_en   = r_q.wr_en;
    assign fifo_wr_data = buf_rd_data;

endmodule

// File: rtl/rx_burst_writer_chk.sv
module rx_burst_writer_chk #(
    parameter int BURST_WORDS = 32,
    parameter int CNT_W       = 16,
    parameter int SPACE_LSB   = 6,
    parameter int LEN_W       = 32,
    parameter int LVL_W       = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] start_len,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] fifo_wr_cnt,
    input logic             fifo_wr_en,
    input logic [LVL_W-1:0] buf_level,
    input logic             buf_rd_en
);
    localparam int RUN_W = $clog2(BURST_WORDS + 2);

    logic [RUN_W-1:0] run_q;
    logic             room_w;

    assign room_w = ~&fifo_wr_cnt[CNT_W-1:SPACE_LSB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (fifo_wr_en) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R3
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> (run_q < RUN_W'(BURST_WORDS)));

    // R3
    burst_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr_en) |-> (run_q == RUN_W'(BURST_WORDS)));

    // R5
    room_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd_en) |-> $past(room_w));

    // R6
    level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd_en) |-> ($past(buf_level) >= LVL_W'(BURST_WORDS)));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (start_len != '0)) |=> busy);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (start_len == '0)) |=> (!busy && !done));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fifo_wr_en && !buf_rd_en));

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(fifo_wr_en) && $past(busy)));

endmodule

bind rx_burst_writer rx_burst_writer_chk #(
    .BURST_WORDS(BURST_WORDS),
    .CNT_W      (CNT_W),
    .SPACE_LSB  (SPACE_LSB),
    .LEN_W      (LEN_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_len  (start_len),
    .busy       (busy),
    .done       (done),
    .fifo_wr_cnt(fifo_wr_cnt),
    .fifo_wr_en (fifo_wr_en),
    .buf_level  (buf_level),
    .buf_rd_en  (buf_rd_en)
);

// File: tb/rx_burst_writer_test.sv
`timescale 1ns/1ps
module rx_burst_writer_test;
    localparam int DATA_W = 128;
    localparam int LEN_W  = 32;
    localparam int LVL_W  = 10;
    localparam int BW     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  start_len = '0;
    logic              busy, done, fifo_wr_en, buf_rd_en;
    logic [15:0]       fifo_wr_cnt = '0;
    logic [DATA_W-1:0] fifo_wr_data;
    logic [LVL_W-1:0]  buf_level;
    logic [DATA_W-1:0] buf_rd_data = '0;

    int unsigned fill_total = 100000;
    int unsigned rd_ptr = 0;
    int unsigned exp_idx = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    int beats, bursts, run_len, bad_run, gap, min_gap, max_gap, data_err, done_cnt;
    bit prev_wr;

    always #2 clk = ~clk;

    rx_burst_writer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
        .busy(busy), .done(done), .fifo_wr_cnt(fifo_wr_cnt),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .buf_level(buf_level), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data)
    );

    // Buffer model: registered read port, one cycle of latency.
    assign buf_level = ((fill_total - rd_ptr) > 512) ? LVL_W'(512) : LVL_W'(fill_total - rd_ptr);
    always @(posedge clk) begin
        if (buf_rd_en) begin
            buf_rd_data <= DATA_W'(rd_ptr);
            rd_ptr      <= rd_ptr + 1;
        end
    end

    // Output monitor on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (fifo_wr_en) begin
                if (fifo_wr_data !== DATA_W'(exp_idx)) data_err++;
                exp_idx++;
                beats++;
                if (!prev_wr) begin
                    if (bursts > 0) begin
                        if (gap < min_gap) min_gap = gap;
                        if (gap > max_gap) max_gap = gap;
                    end
                    bursts++;
                    run_len = 0;
                end
                run_len++;
                gap = 0;
            end else begin
                if (prev_wr && run_len != BW) bad_run++;
                gap++;
            end
            prev_wr = fifo_wr_en;
        end
    end

    task automatic clear_stats();
        beats = 0; bursts = 0; run_len = 0; bad_run = 0; gap = 0;
        min_gap = 1000000; max_gap = 0; data_err = 0; done_cnt = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        start = 1'b1;
        start_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_stats();
        prev_wr = 0;
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!busy && !done && !fifo_wr_en && !buf_rd_en, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fifo_wr_en && !buf_rd_en, "R1 after reset", int'(busy), 0);

        // R9: zero length ignored
        clear_stats();
        pulse_start(0);
        for (int k = 0; k < 6; k++) begin
            chk(!busy, "R9 busy", int'(busy), 0);
            @(negedge clk);
        end
        chk(beats == 0 && done_cnt == 0, "R9 writes", beats + done_cnt, 0);

        // R2 R4 R8: exact timing of a single-sector command
        begin
            int first_wr = -1, first_rd = -1, fall = -1, done_at = -1;
            bit busy1;
            clear_stats();
            @(negedge clk);
            start = 1'b1; start_len = 1;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (k == 1) busy1 = busy;
                if (fifo_wr_en && first_wr < 0) first_wr = k;
                if (buf_rd_en && first_rd < 0) first_rd = k;
                if (!busy && fall < 0) fall = k;
                if (done && done_at < 0) done_at = k;
            end
            chk(busy1, "R2 busy next cycle", int'(busy1), 1);
            chk(first_rd == 2, "R2 first read", first_rd, 2);
            chk(first_wr == 3, "R2 first write", first_wr, 3);
            chk(first_wr - first_rd == 1, "R4 read leads write", first_wr - first_rd, 1);
            chk(fall == 35, "R8 busy fall", fall, 35);
            chk(done_at == 35 && done_cnt == 1, "R8 done pulse", done_at, 35);
            chk(beats == 32 && bad_run == 0, "R3 burst length", beats, 32);
            chk(data_err == 0, "R4 data order", data_err, 0);
        end

        // R7: gaps inside a four-sector command
        clear_stats();
        pulse_start(4);
        wait_idle();
        chk(bursts == 4 && beats == 128, "R8 four sectors", beats, 128);
        chk(min_gap == 1 && max_gap == 1, "R7 gap", max_gap, 1);
        chk(bad_run == 0 && data_err == 0, "R3 runs and data", bad_run + data_err, 0);

        // R5: sweep of the room field and the ignored low bits
        for (int hi = 1020; hi <= 1023; hi++) begin
            for (int j = 0; j < 3; j++) begin
                int lo;
                lo = (j == 0) ? 0 : ((j == 1) ? 21 : 63);
                clear_stats();
                fifo_wr_cnt = 16'((hi << 6) | lo);
                pulse_start(1);
                repeat (12) @(negedge clk);
                if (hi == 1023) begin
                    chk(beats == 0 && busy, "R5 full blocks", beats, 0);
                    fifo_wr_cnt = 16'h0000;
                end else begin
                    chk(beats > 0, "R5 room allows", beats, 10);
                end
                wait_idle();
                chk(beats == 32 && data_err == 0, "R5 burst after gate", beats, 32);
            end
        end
        fifo_wr_cnt = '0;

        // R6: data gate at 31 and 32 words
        clear_stats();
        fill_total = rd_ptr + 31;
        pulse_start(1);
        repeat (15) @(negedge clk);
        chk(beats == 0, "R6 level 31 blocks", beats, 0);
        fill_total = fill_total + 1;
        wait_idle();
        chk(beats == 32 && data_err == 0, "R6 level 32 starts", beats, 32);

        // R6: starvation between bursts
        clear_stats();
        fill_total = rd_ptr + 42;
        pulse_start(2);
        repeat (60) @(negedge clk);
        chk(beats == 32 && busy, "R6 stall mid command", beats, 32);
        fill_total = 1000000;
        wait_idle();
        chk(beats == 64 && bursts == 2 && data_err == 0, "R6 resume", beats, 64);

        // R10: start while busy ignored
        clear_stats();
        pulse_start(1);
        repeat (5) @(negedge clk);
        pulse_start(3);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(beats == 32 && done_cnt == 1 && !busy, "R10 second start", beats, 32);

        // R8: length sweep
        for (int n = 1; n <= 6; n++) begin
            clear_stats();
            fifo_wr_cnt = 16'(n * 5000);
            pulse_start(n);
            wait_idle();
            chk(beats == n * 32 && bursts == n, "R8 length sweep", beats, n * 32);
            chk(done_cnt == 1 && bad_run == 0 && data_err == 0, "R8 sweep integrity",
                done_cnt + bad_run + data_err, 1);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule